// File: doc/BRIEF.md
# Serial Word-Boundary Aligner

This block sits behind the bit-recovery stage of a single-pair serial link. It accepts one recovered bit per cycle whenever a bit-valid strobe is high and rebuilds 22-bit parallel words. On the wire, each word is a 25-bit frame. A fixed zero lead bit comes first. The 22 data bits follow, least significant bit first. Two trailing guard bits close the frame, and both must carry the complement of the last data bit. Because of this, every frame contains at least one level change, and the frame shape can be recognised without any other marker.

After the link is enabled, the block searches every bit position for a window that has the frame shape. It tracks all 25 possible offsets at the same time. It declares lock only when one offset has passed the frame test on a parameterised number of consecutive frames. Once locked, it checks every frame. A frame that fails the test is treated as a boundary error. The block then stops delivering words, raises a request that pulls the link high, and stays down until the transmitter takes the link through a power-down and power-up cycle. After that it searches again. While the link-enable input is low, searching, checking and the error request are all suppressed.

Top module: `sbound_aligner`

## Requirements
- R1: While reset is high, and in the cycle after reset, `word_vld` and `pull_req` are low and `word_data` is zero.
- R2: A frame is 25 bits in arrival order: lead bit 0, data bits d0 to d21, then two guard bits that each equal NOT d21. The delivered word has bit i equal to di. `word_vld` is high for exactly one cycle, in the cycle after the clock edge that accepted the frame's last guard bit.
- R3: During search, no word is delivered until one offset has passed the frame test on LOCK_FRAMES frames in a row, each 25 accepted bits apart (default 2). The frame that completes the run is the first word delivered.
- R4: During search, a failed frame test at an offset resets that offset's run of passes, so counting starts again from zero there.
- R5: Any number of bits before the first frame does not stop lock. Each offset is tracked on its own, so lock is found wherever the frames begin.
- R6: Once locked, every frame is tested. A nonzero lead bit, or either guard bit not equal to NOT d21, is a boundary error. The failing frame is not delivered, and `pull_req` goes high in the cycle after its last bit.
- R7: After an error, `pull_req` stays high and no words are delivered for as long as `link_run` stays high. When `link_run` goes low, `pull_req` falls. A later high level on `link_run` restarts the search from empty.
- R8: While `link_run` is low, bits are not tested and no error is raised: `word_vld` and `pull_req` stay low, even if the frames are malformed.
- R9: A bit presented in a cycle where `ser_vld` is low is ignored. Gaps between valid bits do not change framing or lock.
- R10: `word_data` is zero in every cycle where `word_vld` is low. This includes search and the down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_run | input | 1 | Link enabled by the transmitter; low means power-down |
| ser_bit | input | 1 | Recovered serial bit |
| ser_vld | input | 1 | `ser_bit` carries a bit this cycle |
| word_data | output | DATA_W | Recovered word, d0 at bit 0 |
| word_vld | output | 1 | One-cycle strobe for `word_data` |
| pull_req | output | 1 | Request to pull the link high after a boundary error |

## Verification
The bench checks that a run of passes at one offset is broken by a malformed frame in the middle. A design that did not reset that offset would lock one frame too early and deliver a word. Errors are injected in each of the three framing positions: the first guard bit, the second guard bit, and the lead bit. A checker that looked at only one guard bit, or that ignored the lead bit, would deliver the bad word and leave `pull_req` low. Malformed frames are also sent while the link is disabled, where a design that kept checking would raise a spurious request. Bits are sent with idle gaps between them and with junk on `ser_bit` during the gaps, so a design that advances its phase on unqualified cycles would drift off the boundary.

// File: rtl/sba_pkg.sv
package sba_pkg;

    localparam int unsigned SBA_DATA_W_DEF = 22;
    localparam int unsigned SBA_OVERHEAD   = 3;   // lead bit + two guard bits

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2,
        ST_DOWN = 2'd3
    } link_st_e;

    function automatic int unsigned frame_len(input int unsigned dw);
        return dw + SBA_OVERHEAD;
    endfunction

endpackage

// File: rtl/sba_window.sv
module sba_window #(
    parameter int unsigned FRAME_BITS = 25
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic [FRAME_BITS-1:0] win_next
);
    logic [FRAME_BITS-1:0] win_q;

    // oldest bit sits at index 0, newest at the top
    assign win_next = {bit_in, win_q[FRAME_BITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= win_next;
        end
    end
endmodule

// File: rtl/sba_frame_decode.sv
module sba_frame_decode #(
    parameter int unsigned DATA_W = 22
) (
    input  logic [DATA_W+2:0] win,
    output logic              frame_ok,
    output logic [DATA_W-1:0] data
);
    logic lead_bit;
    logic last_data;
    logic guard_a;
    logic guard_b;

    assign lead_bit  = win[0];
    assign data      = win[DATA_W:1];
    assign last_data = win[DATA_W];
    assign guard_a   = win[DATA_W+1];
    assign guard_b   = win[DATA_W+2];

    always_comb begin
        frame_ok = 1'b1;
        if (lead_bit)                frame_ok = 1'b0;
        if (guard_a != ~last_data)   frame_ok = 1'b0;
        if (guard_b != ~last_data)   frame_ok = 1'b0;
    end
endmodule

// File: rtl/sba_hunt_bank.sv
module sba_hunt_bank #(
    parameter int unsigned FRAME_BITS  = 25,
    parameter int unsigned LOCK_FRAMES = 2,
    parameter int unsigned PW          = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [PW-1:0] ph,
    input  logic          ok,
    output logic          lock_hit
);
    localparam int unsigned CW    = (LOCK_FRAMES > 1) ? $clog2(LOCK_FRAMES) : 1;
    localparam int unsigned SLOTS = 1 << PW;
    localparam logic [CW-1:0] LIM = CW'(LOCK_FRAMES - 1);

    logic [SLOTS-1:0] at_lim;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < FRAME_BITS) begin : g_live
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    cnt_q <= '0;
                end else if (step && (ph == PW'(g))) begin
                    if (!ok)               cnt_q <= '0;
                    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
                end
            end

            assign at_lim[g] = (cnt_q == LIM);

            a_r4_run_bounded: assert property (@(posedge clk) disable iff (rst)
                (cnt_q <= LIM));
        end else begin : g_pad
            assign at_lim[g] = 1'b0;
        end
    end

    assign lock_hit = ok && at_lim[ph];
endmodule

// File: rtl/sba_sequencer.sv
module sba_sequencer
    import sba_pkg::*;
#(
    parameter int unsigned DATA_W     = 22,
    parameter int unsigned FRAME_BITS = 25,
    parameter int unsigned PW         = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_run,
    input  logic              ser_vld,
    input  logic              frame_ok,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              lock_hit,
    output logic              hunt_ok,
    output logic [PW-1:0]     ph,
    output logic              bank_clr,
    output logic              bank_step,
    output logic [DATA_W-1:0] word_data,
    output logic              word_vld,
    output logic              pull_req
);
    localparam int unsigned FILL_W = $clog2(FRAME_BITS);
    localparam logic [PW-1:0]     PH_LAST   = PW'(FRAME_BITS - 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(FRAME_BITS - 1);

    link_st_e          st_q, st_d;
    logic [PW-1:0]     ph_q, ph_d, ph_inc, anc_q, anc_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic              wv_d;
    logic [DATA_W-1:0] wd_d;
    logic              full;

    assign full      = (fill_q == FILL_FULL);
    assign hunt_ok   = frame_ok && full;
    assign ph        = ph_q;
    assign ph_inc    = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    assign bank_clr  = (st_q != ST_HUNT);
    assign bank_step = (st_q == ST_HUNT) && link_run && ser_vld;
    assign pull_req  = (st_q == ST_DOWN);

    always_comb begin
        st_d   = st_q;
        ph_d   = ph_q;
        anc_d  = anc_q;
        fill_d = fill_q;
        wv_d   = 1'b0;
        wd_d   = '0;
        if (!link_run) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_OFF: begin
                    st_d   = ST_HUNT;
                    ph_d   = '0;
                    fill_d = '0;
                end
                ST_HUNT: begin
                    if (ser_vld) begin
                        ph_d = ph_inc;
                        if (!full) fill_d = fill_q + 1'b1;
                        if (lock_hit) begin
                            st_d  = ST_LOCK;
                            anc_d = ph_q;
                            wv_d  = 1'b1;
                            wd_d  = frame_data;
                        end
                    end
                end
                ST_LOCK: begin
                    if (ser_vld) begin
                        ph_d = ph_inc;
                        if (ph_q == anc_q) begin
                            if (frame_ok) begin
                                wv_d = 1'b1;
                                wd_d = frame_data;
                            end else begin
                                st_d = ST_DOWN;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_OFF;
            ph_q      <= '0;
            anc_q     <= '0;
            fill_q    <= '0;
            word_vld  <= 1'b0;
            word_data <= '0;
        end else begin
            st_q      <= st_d;
            ph_q      <= ph_d;
            anc_q     <= anc_d;
            fill_q    <= fill_d;
            word_vld  <= wv_d;
            word_data <= wd_d;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!word_vld && !pull_req && word_data == '0));

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !link_run |=> (!word_vld && !pull_req));

    a_r6_bad_frame_dropped: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_req) |-> !word_vld);

    a_r7_request_holds: assert property (@(posedge clk) disable iff (rst)
        (pull_req && link_run) |=> (pull_req && !word_vld));

    a_r9_word_needs_bit: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $past(ser_vld && link_run));

    a_r10_data_quiet: assert property (@(posedge clk) disable iff (rst)
        !word_vld |-> (word_data == '0));

    a_r3_lock_from_hunt: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCK && $past(st_q) != ST_LOCK) |-> ($past(st_q) == ST_HUNT));

    a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
        (ph_q <= PH_LAST));
endmodule

// File: rtl/sbound_aligner.sv
module sbound_aligner
    import sba_pkg::*;
#(
    parameter int unsigned DATA_W      = SBA_DATA_W_DEF,
    parameter int unsigned LOCK_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_run,
    input  logic              ser_bit,
    input  logic              ser_vld,
    output logic [DATA_W-1:0] word_data,
    output logic              word_vld,
    output logic              pull_req
);
    localparam int unsigned FRAME_BITS = frame_len(DATA_W);
    localparam int unsigned PW         = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] win_next;
    logic                  frame_ok;
    logic [DATA_W-1:0]     frame_data;
    logic                  hunt_ok;
    logic                  lock_hit;
    logic [PW-1:0]         ph;
    logic                  bank_clr;
    logic                  bank_step;

    sba_window #(.FRAME_BITS(FRAME_BITS)) u_win (
        .clk      (clk),
        .rst      (rst),
        .shift_en (ser_vld),
        .bit_in   (ser_bit),
        .win_next (win_next)
    );

    sba_frame_decode #(.DATA_W(DATA_W)) u_dec (
        .win      (win_next),
        .frame_ok (frame_ok),
        .data     (frame_data)
    );

    sba_hunt_bank #(
        .FRAME_BITS  (FRAME_BITS),
        .LOCK_FRAMES (LOCK_FRAMES),
        .PW          (PW)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr      (bank_clr),
        .step     (bank_step),
        .ph       (ph),
        .ok       (hunt_ok),
        .lock_hit (lock_hit)
    );

    sba_sequencer #(
        .DATA_W     (DATA_W),
        .FRAME_BITS (FRAME_BITS),
        .PW         (PW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .link_run   (link_run),
        .ser_vld    (ser_vld),
        .frame_ok   (frame_ok),
        .frame_data (frame_data),
        .lock_hit   (lock_hit),
        .hunt_ok    (hunt_ok),
        .ph         (ph),
        .bank_clr   (bank_clr),
        .bank_step  (bank_step),
        .word_data  (word_data),
        .word_vld   (word_vld),
        .pull_req   (pull_req)
    );
endmodule

// File: tb/sim_sbound_aligner.sv
module sim_sbound_aligner;
    localparam int DW = 22;
    localparam int LF = 2;
    localparam int FB = DW + 3;
    localparam logic [DW-1:0] PAT_A    = 22'h155555;
    localparam logic [DW-1:0] PAT_ONES = 22'h3FFFFF;

    logic          clk = 1'b0;
    logic          rst;
    logic          link_run;
    logic          ser_bit;
    logic          ser_vld;
    logic [DW-1:0] word_data;
    logic          word_vld;
    logic          pull_req;

    always #4 clk = ~clk;

    sbound_aligner #(.DATA_W(DW), .LOCK_FRAMES(LF)) u0 (
        .clk(clk), .rst(rst), .link_run(link_run), .ser_bit(ser_bit),
        .ser_vld(ser_vld), .word_data(word_data), .word_vld(word_vld),
        .pull_req(pull_req)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    started = 0;

    // ---------------- behavioural reference ----------------
    int            m_st = 0;          // 0 off, 1 search, 2 locked, 3 down
    bit            mq[$];
    int            mcnt[FB];
    int            m_ph = 0;
    int            m_anc = 0;
    bit            e_vld = 0;
    logic [DW-1:0] e_data = '0;
    bit            e_pull = 0;

    function automatic bit m_good();
        return (mq.size() == FB) && (mq[0] == 1'b0) &&
               (mq[FB-2] == mq[FB-1]) && (mq[FB-1] != mq[FB-3]);
    endfunction

    function automatic logic [DW-1:0] m_word();
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) w[i] = mq[1+i];
        return w;
    endfunction

    task automatic m_restart();
        mq.delete();
        m_ph = 0;
        for (int i = 0; i < FB; i++) mcnt[i] = 0;
    endtask

    always @(posedge clk) begin
        e_vld  = 0;
        e_data = '0;
        if (rst || !link_run) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_restart(); end
                1: if (ser_vld) begin
                    mq.push_back(ser_bit);
                    if (mq.size() > FB) void'(mq.pop_front());
                    if (m_good()) begin
                        if (mcnt[m_ph] >= LF - 1) begin
                            m_st = 2; m_anc = m_ph; e_vld = 1; e_data = m_word();
                        end else mcnt[m_ph]++;
                    end else mcnt[m_ph] = 0;
                    m_ph = (m_ph + 1) % FB;
                end
                2: if (ser_vld) begin
                    mq.push_back(ser_bit);
                    if (mq.size() > FB) void'(mq.pop_front());
                    if (m_ph == m_anc) begin
                        if (m_good()) begin e_vld = 1; e_data = m_word(); end
                        else m_st = 3;
                    end
                    m_ph = (m_ph + 1) % FB;
                end
                default: ;
            endcase
        end
        e_pull = (m_st == 3);
    end

    // ---------------- per-cycle comparison and capture ----------------
    logic [DW-1:0] got[$];

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (word_vld !== e_vld || word_data !== e_data || pull_req !== e_pull) begin
                errors++;
                $display("FAIL %s cycle compare: vld=%0b data=%h pull=%0b expected vld=%0b data=%h pull=%0b",
                         cur_req, word_vld, word_data, pull_req, e_vld, e_data, e_pull);
            end
            if (word_vld === 1'b1) got.push_back(word_data);
        end
    end

    task automatic chk(input bit pass, input string tag, input longint act, input longint exp);
        checks++;
        if (!pass) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic put_bit(input bit b);
        @(negedge clk);
        ser_bit = b;
        ser_vld = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            ser_vld = 1'b0;
            ser_bit = 1'($urandom % 2);
        end
    endtask

    // kind: 0 good, 1 first guard wrong, 2 second guard wrong, 3 lead bit set
    task automatic send_frame(input logic [DW-1:0] d, input int kind, input int gap);
        bit fr[FB];
        fr[0] = (kind == 3);
        for (int i = 0; i < DW; i++) fr[1+i] = d[i];
        fr[FB-2] = (kind == 1) ? d[DW-1] : ~d[DW-1];
        fr[FB-1] = (kind == 2) ? d[DW-1] : ~d[DW-1];
        for (int i = 0; i < FB; i++) begin
            put_bit(fr[i]);
            if (gap > 0) idle(gap);
        end
    endtask

    task automatic cycle_link();
        @(negedge clk); link_run = 1'b0; ser_vld = 1'b0;
        idle(2);
        @(negedge clk); link_run = 1'b1;
        idle(2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [DW-1:0] sent[$];
        int base;
        rst = 1'b1; link_run = 1'b0; ser_bit = 1'b0; ser_vld = 1'b0;
        @(negedge clk);
        started = 1;
        repeat (2) @(negedge clk);
        chk(word_vld == 0 && pull_req == 0 && word_data == 0, "R1 reset outputs",
            {word_vld, pull_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(word_vld == 0 && pull_req == 0, "R1 after reset", {word_vld, pull_req}, 0);
        link_run = 1'b1;
        idle(2);

        // R3 / R2: lock needs two frames at one offset
        cur_req = "R3";
        send_frame(PAT_A, 0, 0); idle(2);
        chk(got.size() == 0, "R3 no word after one frame", got.size(), 0);
        send_frame(PAT_A, 0, 0); send_frame(PAT_A, 0, 0); idle(2);
        chk(got.size() == 2, "R3 words after lock", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == PAT_A, "R2 first word bits", got[0], PAT_A);
            chk(got[1] == PAT_A, "R2 second word bits", got[1], PAT_A);
        end
        got.delete();

        // R6: first guard bit wrong
        cur_req = "R6";
        send_frame(PAT_A, 1, 0); idle(2);
        chk(pull_req == 1, "R6 request after guard error", pull_req, 1);
        chk(got.size() == 0, "R6 bad frame dropped", got.size(), 0);

        // R7: request sticky, then released by link power-down
        cur_req = "R7";
        send_frame(PAT_A, 0, 0); send_frame(PAT_A, 0, 0); idle(2);
        chk(pull_req == 1, "R7 request holds", pull_req, 1);
        chk(got.size() == 0, "R7 no words while down", got.size(), 0);
        @(negedge clk); link_run = 1'b0;
        idle(2);
        chk(pull_req == 0, "R7 request released", pull_req, 0);

        // R5: leading junk then frames
        @(negedge clk); link_run = 1'b1;
        idle(2);
        cur_req = "R5";
        for (int i = 0; i < 7; i++) put_bit(1'($urandom % 2));
        for (int i = 0; i < 3; i++) send_frame(PAT_ONES, 0, 0);
        idle(2);
        chk(got.size() == 2, "R5 lock after junk", got.size(), 2);
        if (got.size() > 0) chk(got[0] == PAT_ONES, "R5 word value", got[0], PAT_ONES);

        // R10: random words while locked, data quiet between strobes
        cur_req = "R10";
        base = got.size();
        for (int i = 0; i < 6; i++) begin
            logic [DW-1:0] d;
            d = DW'($urandom);
            sent.push_back(d);
            send_frame(d, 0, 0);
        end
        idle(2);
        chk(got.size() == base + 6, "R10 random words count", got.size(), base + 6);
        for (int i = 0; i < 6; i++)
            if (got.size() > base + i)
                chk(got[base+i] == sent[i], "R2 random word value", got[base+i], sent[i]);

        // R6: lead bit set
        cur_req = "R6";
        base = got.size();
        send_frame(DW'($urandom), 3, 0); idle(2);
        chk(pull_req == 1, "R6 request after lead bit error", pull_req, 1);
        chk(got.size() == base, "R6 lead error dropped", got.size(), base);

        // R4: a broken run restarts counting
        cycle_link();
        cur_req = "R4";
        got.delete();
        send_frame(PAT_A, 0, 0); send_frame(PAT_A, 2, 0); send_frame(PAT_A, 0, 0);
        idle(2);
        chk(got.size() == 0, "R4 no lock across bad frame", got.size(), 0);
        send_frame(PAT_A, 0, 0); idle(2);
        chk(got.size() == 1, "R4 lock after fresh run", got.size(), 1);

        // R8: malformed frames while disabled
        cur_req = "R8";
        @(negedge clk); link_run = 1'b0;
        send_frame(PAT_A, 1, 0); send_frame(PAT_A, 3, 0); idle(2);
        chk(pull_req == 0, "R8 no request while disabled", pull_req, 0);
        chk(got.size() == 1, "R8 no words while disabled", got.size(), 1);

        // R9: gaps with junk between valid bits
        @(negedge clk); link_run = 1'b1;
        idle(2);
        cur_req = "R9";
        got.delete();
        send_frame(PAT_ONES, 0, 1); send_frame(PAT_ONES, 0, 2); send_frame(PAT_A, 0, 3);
        idle(4);
        chk(got.size() == 2, "R9 words with gaps", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == PAT_ONES, "R9 first gapped word", got[0], PAT_ONES);
            chk(got[1] == PAT_A, "R9 second gapped word", got[1], PAT_A);
        end
        chk(pull_req == 0, "R9 no spurious error", pull_req, 0);

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule